// File: doc/BRIEF.md
# Transmit cell extraction buffer with byte-wide CPU readout

This block holds fixed-length ATM cells that an upstream filter has marked for copying, and lets a byte-wide microprocessor bus read them out. Cells enter on a 32-bit word port. Each word carries a valid strobe, and the first word of a cell also carries a start-of-cell strobe. A cell takes 14 words: 53 bytes padded to 56. The buffer has room for a parameterised number of complete cells, two by default. A cell that arrives while every slot holds a complete cell is discarded whole.

Software finds cells in one of two ways. It can poll a cell-ready flag in the control register, or it can enable the cell-loaded interrupt. It then reads each 32-bit word as four byte reads, most-significant lane first. Reading the least-significant lane moves to the next word.

The block also keeps six event flags in a shared pair of registers: an enable register and a status register. The flags are cell loaded, insertion done, extraction overflow, insertion overflow, HEC error and parity error. The status register clears when it is read. An active-low interrupt pin is asserted while any enabled flag is pending.

Top module: `cell_xbuf`

## Requirements
- R1: After reset, the control, enable and status registers all read 0, and `irq_n` is high.
- R2: Address 0 is the control register. Its bit 3 reads 1 while at least one complete cell waits in the buffer, and 0 otherwise. Its other bits read 0.
- R3: A cell is captured as exactly 14 valid words, starting with the word that carries `cw_sof`. A valid word without `cw_sof` is ignored when no cell is being captured. A new `cw_sof` in the middle of a cell abandons the partial cell and starts a new one.
- R4: Addresses 4, 5, 6 and 7 return bits 31:24, 23:16, 15:8 and 7:0 of the current word of the oldest cell. A read of address 7 advances to the next word. After the 14th word is read, the cell is released, and the ready flag reflects the release on the next clock. When no cell is ready, these addresses read 0 and do not advance.
- R5: The buffer holds `SLOTS` complete cells and hands them out in arrival order. A `cw_sof` that arrives while all slots are full drops that whole cell and sets status bit 3.
- R6: Address 1 is the enable register. It is read/write, with bit 5 for cell loaded, bit 4 for insertion done, bit 3 for extraction overflow, bit 2 for insertion overflow, bit 1 for HEC error and bit 0 for parity error. Bits 7:6 read 0.
- R7: Address 2 is the status register, with the same bit positions as the enable register. Bit 5 is set when a cell completes. Bits 4, 2, 1 and 0 are set by the `ins_done_evt`, `ins_ovf_evt`, `hec_err_evt` and `par_err_evt` inputs. Writes to this register are ignored.
- R8: A read of the status register returns its value and then clears it. An event that occurs in the same cycle as that read stays set.
- R9: `irq_n` is low exactly while some status bit and its enable bit are both 1. It goes high on the cycle after a read that clears every enabled pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_data | input | 32 | Cell word; first byte of the cell in bits 31:24 |
| cw_sof | input | 1 | Marks the first word of a cell |
| cw_valid | input | 1 | Word strobe |
| ins_done_evt | input | 1 | Insertion-done event pulse |
| ins_ovf_evt | input | 1 | Insertion-overflow event pulse |
| hec_err_evt | input | 1 | HEC error event pulse |
| par_err_evt | input | 1 | Parity error event pulse |
| cpu_addr | input | 3 | Register address |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the cycle of `cpu_rd` |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest situations to reach are coincidences. One is a cell finishing, or an error pulse arriving, in the same cycle that software reads and clears the status register. Another is a start-of-cell landing while the buffer is full and software is reading out the last word that frees a slot. The stimulus fills both slots, reads most of the oldest cell, and then issues the final lane-0 read in the same cycle as a new start-of-cell and an error pulse. It also reads status in the cycle a cell completes. A behavioural queue model predicts every byte and the interrupt level on each clock.

// File: rtl/cell_xbuf.sv
module cell_xbuf #(
  parameter int WPC   = 14,
  parameter int SLOTS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cw_data,
  input  logic        cw_sof,
  input  logic        cw_valid,
  input  logic        ins_done_evt,
  input  logic        ins_ovf_evt,
  input  logic        hec_err_evt,
  input  logic        par_err_evt,
  input  logic [2:0]  cpu_addr,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        irq_n
);
  localparam int DEPTH = WPC * SLOTS;
  localparam int IW = $clog2(WPC);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int MW = $clog2(DEPTH);
  localparam int CW = $clog2(SLOTS + 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_ISTS = 3'd2;
  localparam logic [2:0] A_LANE3 = 3'd4, A_LANE2 = 3'd5, A_LANE1 = 3'd6, A_LANE0 = 3'd7;

  logic [31:0]   mem [DEPTH];
  logic [SW-1:0] wr_slot, rd_slot;
  logic [IW-1:0] wr_idx, rd_idx;
  logic          wr_busy;
  logic [CW-1:0] cnt;
  logic [5:0]    en_q, sts_q;

  wire          sof_go   = cw_valid & cw_sof;
  wire          full     = (cnt == CW'(SLOTS));
  wire          wr_take  = sof_go ? !full : (cw_valid & wr_busy);
  wire [IW-1:0] widx     = sof_go ? '0 : wr_idx;
  wire          cell_done = wr_take && (widx == IW'(WPC - 1));
  wire          drop     = sof_go & full;
  wire          avail    = (cnt != '0);
  wire          rd_hit   = cpu_rd && (cpu_addr == A_LANE0) && avail;
  wire          rd_last  = rd_hit && (rd_idx == IW'(WPC - 1));
  wire          sts_rd   = cpu_rd && (cpu_addr == A_ISTS);
  wire [5:0]    evt      = {cell_done, ins_done_evt, drop, ins_ovf_evt, hec_err_evt, par_err_evt};
  wire [MW-1:0] waddr    = MW'(wr_slot) * MW'(WPC) + MW'(widx);
  wire [MW-1:0] raddr    = MW'(rd_slot) * MW'(WPC) + MW'(rd_idx);
  wire [31:0]   rword    = avail ? mem[raddr] : 32'd0;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] s);
    return (s == SW'(SLOTS - 1)) ? '0 : s + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (wr_take) mem[waddr] <= cw_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_slot <= '0;
      wr_idx  <= '0;
      wr_busy <= 1'b0;
    end else if (cell_done) begin
      wr_busy <= 1'b0;
      wr_idx  <= '0;
      wr_slot <= nxt(wr_slot);
    end else if (sof_go) begin
      wr_busy <= !full;
      wr_idx  <= full ? '0 : IW'(1);
    end else if (wr_take) begin
      wr_idx <= wr_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_slot <= '0;
      rd_idx  <= '0;
    end else if (rd_last) begin
      rd_idx  <= '0;
      rd_slot <= nxt(rd_slot);
    end else if (rd_hit) begin
      rd_idx <= rd_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      cnt   <= cnt + CW'(cell_done) - CW'(rd_last);
      sts_q <= (sts_rd ? 6'd0 : sts_q) | evt;
      if (cpu_wr && cpu_addr == A_IEN) en_q <= cpu_wdata[5:0];
    end
  end

  assign irq_n = ~|(sts_q & en_q);

  always_comb begin
    cpu_rdata = 8'd0;
    if (cpu_rd)
      case (cpu_addr)
        A_CTRL:  cpu_rdata = {4'd0, avail, 3'd0};
        A_IEN:   cpu_rdata = {2'd0, en_q};
        A_ISTS:  cpu_rdata = {2'd0, sts_q};
        A_LANE3: cpu_rdata = rword[31:24];
        A_LANE2: cpu_rdata = rword[23:16];
        A_LANE1: cpu_rdata = rword[15:8];
        A_LANE0: cpu_rdata = rword[7:0];
        default: cpu_rdata = 8'd0;
      endcase
  end
endmodule

// File: rtl/cell_xbuf_chk.sv
module cell_xbuf_chk #(
  parameter int SLOTS = 2,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_rd,
  input logic [2:0]    cpu_addr,
  input logic [7:0]    cpu_rdata,
  input logic          cw_valid,
  input logic          cw_sof,
  input logic          ins_done_evt,
  input logic          ins_ovf_evt,
  input logic          hec_err_evt,
  input logic          par_err_evt,
  input logic          irq_n,
  input logic [5:0]    sts_q,
  input logic [CW-1:0] cnt
);
  wire quiet_rd = cpu_rd && cpu_addr == 3'd2 && !cw_valid &&
                  !ins_done_evt && !ins_ovf_evt && !hec_err_evt && !par_err_evt;

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_rd |=> (sts_q == 6'd0));
  assert_irq_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_rd |=> irq_n);
  assert_hec_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hec_err_evt |=> sts_q[1]);
  assert_drop_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && cw_sof && cnt == CW'(SLOTS)) |=> sts_q[3]);
  assert_no_overfill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(SLOTS));
  assert_unused_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr == 3'd1) |-> (cpu_rdata[7:6] == 2'd0));
endmodule

bind cell_xbuf cell_xbuf_chk #(.SLOTS(SLOTS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
  .cpu_rdata(cpu_rdata), .cw_valid(cw_valid), .cw_sof(cw_sof),
  .ins_done_evt(ins_done_evt), .ins_ovf_evt(ins_ovf_evt),
  .hec_err_evt(hec_err_evt), .par_err_evt(par_err_evt),
  .irq_n(irq_n), .sts_q(sts_q), .cnt(cnt)
);

// File: tb/tb_cell_xbuf.sv
module tb_cell_xbuf;
  localparam int WPC = 14, SLOTS = 2;
  logic clk = 0, rst_n = 0;
  logic [31:0] cw_data = 0;
  logic cw_sof = 0, cw_valid = 0, ins_done_evt = 0, ins_ovf_evt = 0, hec_err_evt = 0, par_err_evt = 0;
  logic [2:0] cpu_addr = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata;
  logic irq_n;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cell_xbuf #(.WPC(WPC), .SLOTS(SLOTS)) dut (.*);

  int m_en = 0, m_sts = 0, m_cells = 0, m_rdw = 0;
  bit m_busy = 0;
  logic [31:0] m_q[$];
  logic [31:0] m_cur[$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd();
    case (cpu_addr)
      3'd0: return (m_cells > 0) ? 8 : 0;
      3'd1: return m_en;
      3'd2: return m_sts;
      3'd4, 3'd5, 3'd6, 3'd7:
        return (m_cells > 0) ? int'((m_q[0] >> (8 * (7 - int'(cpu_addr)))) & 32'hff) : 0;
      default: return 0;
    endcase
  endfunction

  task automatic model_update();
    int ev = 0;
    int inc = 0;
    int dec = 0;
    if (cw_valid && cw_sof) begin
      if (m_cells == SLOTS) begin ev |= 8; m_busy = 0; m_cur.delete(); end
      else begin m_busy = 1; m_cur.delete(); m_cur.push_back(cw_data); end
    end else if (cw_valid && m_busy) m_cur.push_back(cw_data);
    if (m_busy && m_cur.size() == WPC) begin
      foreach (m_cur[i]) m_q.push_back(m_cur[i]);
      m_cur.delete(); m_busy = 0; inc = 1; ev |= 32;
    end
    if (cpu_rd && cpu_addr == 3'd7 && m_cells > 0) begin
      void'(m_q.pop_front());
      m_rdw++;
      if (m_rdw == WPC) begin m_rdw = 0; dec = 1; end
    end
    m_cells += inc - dec;
    ev |= (ins_done_evt << 4) | (ins_ovf_evt << 2) | (hec_err_evt << 1) | par_err_evt;
    if (cpu_rd && cpu_addr == 3'd2) m_sts = ev; else m_sts |= ev;
    if (cpu_wr && cpu_addr == 3'd1) m_en = cpu_wdata & 8'h3f;
  endtask

  task automatic step(string tag);
    #1;
    chk("R9 irq level", irq_n, ((m_sts & m_en) == 0) ? 1 : 0);
    if (cpu_rd) chk(tag, cpu_rdata, exp_rd());
    @(posedge clk);
    model_update();
    @(negedge clk);
    cw_valid = 0; cw_sof = 0; cpu_rd = 0; cpu_wr = 0;
    ins_done_evt = 0; ins_ovf_evt = 0; hec_err_evt = 0; par_err_evt = 0;
  endtask

  task automatic rd(logic [2:0] a, string tag);
    cpu_rd = 1; cpu_addr = a; step(tag);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cpu_wr = 1; cpu_addr = a; cpu_wdata = d; step("wr");
  endtask

  task automatic word(logic [31:0] d, bit sof);
    cw_valid = 1; cw_sof = sof; cw_data = d; step("R3 word");
  endtask

  task automatic send_cell(int id, int n);
    for (int i = 0; i < n; i++) word({8'(id), 8'(i), 16'hc35a ^ 16'(id * 97 + i)}, i == 0);
  endtask

  task automatic read_words(int n, string tag);
    for (int w = 0; w < n; w++)
      for (int a = 4; a < 8; a++) rd(3'(a), tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, "R1 ctrl"); rd(3'd1, "R1 ien"); rd(3'd2, "R1 sts");
    chk("R1 irq_n", irq_n, 1);
    rd(3'd7, "R4 empty lane");
    wr(3'd1, 8'hff); rd(3'd1, "R6 enable readback");
    wr(3'd2, 8'h3f); rd(3'd2, "R7 write ignored");
    word(32'hdeadbeef, 0); rd(3'd0, "R3 stray word");
    send_cell(1, 5); send_cell(2, 14);
    rd(3'd0, "R2 ready"); rd(3'd2, "R7 cell flag"); step("R9 release");
    send_cell(3, 13);
    cw_valid = 1; cw_data = 32'h0300_ffff; cpu_rd = 1; cpu_addr = 3'd2; step("R8 read with completion");
    rd(3'd2, "R8 kept event");
    send_cell(4, 14); rd(3'd2, "R5 ovf flag"); rd(3'd2, "R8 cleared");
    read_words(13, "R4 lanes");
    rd(3'd4, "R4 last word"); rd(3'd5, "R4 last word"); rd(3'd6, "R4 last word");
    cpu_rd = 1; cpu_addr = 3'd7; cw_valid = 1; cw_sof = 1; cw_data = 32'h0500_0000;
    hec_err_evt = 1; step("R4 release with sof");
    send_cell(6, 14);
    rd(3'd2, "R7 hec and ovf"); rd(3'd0, "R2 after release");
    read_words(28, "R5 order");
    rd(3'd0, "R2 drained"); rd(3'd6, "R4 empty");
    wr(3'd1, 8'h03);
    ins_done_evt = 1; ins_ovf_evt = 1; step("R9 masked"); rd(3'd2, "R7 ins flags");
    par_err_evt = 1; step("R9 parity"); rd(3'd2, "R8 clear parity"); step("R9 high");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule